// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two binary floating-point operands and reports the outcome as a four-bit NZCV condition code. Later conditional logic can test that code for the IEEE 754 relations: equal, less, greater and unordered. The exponent and fraction widths are parameters. The defaults give the single-precision layout: one sign bit, an 8-bit exponent and a 23-bit fraction.

The block has two compare flavours, quiet and signaling. The only difference between them is when the invalid-operation flag is raised for a NaN operand. Each flavour also has a variant that ignores the second operand and compares the first operand against positive zero.

A request is one cycle with the valid strobe high. The condition code, the invalid flag and a result-valid pulse appear on the registered outputs in the next cycle. The condition code then holds until the next request.

Top module: `fcmp_flags`

## Requirements
- R1: The opcode is two bits. Bit 1 selects the signaling compare (1) or the quiet compare (0). Bit 0 selects the zero variant (1), which compares operand A against +0.0 and ignores operand B entirely.
- R2: If either compared operand is a NaN (exponent all ones, fraction nonzero), the flags are unordered: NZCV = 0011 (N is bit 3, V is bit 0).
- R3: In the quiet compare, operands that include quiet NaNs (fraction MSB 1) but no signaling NaN leave the invalid flag low. Non-NaN operands also leave it low in both flavours.
- R4: A signaling NaN operand (fraction MSB 0, fraction nonzero) raises the invalid flag in either flavour.
- R5: In the signaling compare, any NaN operand, quiet or signaling, raises the invalid flag.
- R6: For ordered operands, equal gives NZCV = 0110, less gives 1000 and greater gives 0010.
- R7: +0.0 and -0.0 compare as equal in any combination.
- R8: Ordering follows numeric value. Any negative value is less than any positive value. Between two negatives, the larger magnitude is less. Infinities order beyond all finite values, and subnormals order by their magnitude.
- R9: The result-valid output is high exactly in the cycle after a cycle with the strobe high. The flags and the invalid flag for that request are presented in that cycle. The invalid flag is low whenever result-valid is low, and the flags hold their last value between requests.
- R10: After reset, result-valid is low, NZCV is 0000 and the invalid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe, one request per high cycle |
| opcode | input | 2 | Bit 1: signaling compare; bit 0: compare against +0.0 |
| opA | input | 1+EXP_W+MAN_W | First operand |
| opB | input | 1+EXP_W+MAN_W | Second operand, ignored by the zero variants |
| resValid | output | 1 | Result valid, one cycle after the strobe |
| nzcv | output | 4 | Condition flags, N in bit 3 down to V in bit 0 |
| invalidOp | output | 1 | Invalid-operation flag for the presented result |

## Verification
The bench builds the block with a 3-bit exponent and a 2-bit fraction, which makes a 6-bit operand. Every ordered pair of operands is then applied under all four opcodes. That covers every class pairing: both zeros, subnormals, normals, both infinities, quiet and signaling NaNs of each sign, and every operand B value in the zero variants. Each expected result comes from converting the operands to real numbers in the bench. Back-to-back requests and a gap after them check the valid timing and that the flags hold between requests.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Opcode bit 1: signaling flavour, bit 0: compare against +0.0
  typedef enum logic [1:0] {
    OP_QUIET_REG  = 2'b00,
    OP_QUIET_ZERO = 2'b01,
    OP_SIG_REG    = 2'b10,
    OP_SIG_ZERO   = 2'b11
  } fcmp_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic useZero;
    logic sigMode;
  } fcmp_strobe_t;

  // Condition codes, N in bit 3 down to V in bit 0
  localparam logic [3:0] NZCV_EQ = 4'b0110;
  localparam logic [3:0] NZCV_LT = 4'b1000;
  localparam logic [3:0] NZCV_GT = 4'b0010;
  localparam logic [3:0] NZCV_UN = 4'b0011;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]         opnd,
  output logic                 isNan,
  output logic                 isSnan,
  output logic                 isZero,
  output logic                 sign,
  output logic [EXP_W+MAN_W-1:0] mag
);

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] fracField;
  logic             expOnes;
  logic             fracNz;

  always_comb begin
    sign      = opnd[W-1];
    expField  = opnd[W-2:MAN_W];
    fracField = opnd[MAN_W-1:0];
    mag       = opnd[W-2:0];
    expOnes   = &expField;
    fracNz    = |fracField;
    isNan     = expOnes && fracNz;
    isSnan    = isNan && !fracField[MAN_W-1];
    isZero    = !(|mag);
  end

endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   opcode,
  output fcmp_strobe_t strobe,
  output logic         resValid
);

  fcmp_op_e opDec;

  always_comb begin
    opDec          = fcmp_op_e'(opcode);
    strobe.capture = inValid;
    strobe.useZero = (opDec == OP_QUIET_ZERO) || (opDec == OP_SIG_ZERO);
    strobe.sigMode = (opDec == OP_SIG_REG) || (opDec == OP_SIG_ZERO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end

  // R9: result-valid follows the strobe by exactly one cycle
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);

endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W,
  localparam int NOPS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  fcmp_strobe_t strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [3:0]   nzcv,
  output logic         invalidOp
);

  logic [W-1:0]     opSel  [NOPS];
  logic             nanV   [NOPS];
  logic             snanV  [NOPS];
  logic             zeroV  [NOPS];
  logic             signV  [NOPS];
  logic [MAG_W-1:0] magV   [NOPS];

  always_comb begin
    opSel[0] = opA;
    opSel[1] = strobe.useZero ? '0 : opB;
  end

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .opnd  (opSel[i]),
      .isNan (nanV[i]),
      .isSnan(snanV[i]),
      .isZero(zeroV[i]),
      .sign  (signV[i]),
      .mag   (magV[i])
    );
  end

  logic       anyNan;
  logic       anySnan;
  logic       bothZero;
  logic       magEq;
  logic       magGt;
  logic [3:0] nextFlags;
  logic       nextInvalid;

  always_comb begin
    anyNan   = nanV[0] || nanV[1];
    anySnan  = snanV[0] || snanV[1];
    bothZero = zeroV[0] && zeroV[1];
    magEq    = (magV[0] == magV[1]);
    magGt    = (magV[0] > magV[1]);

    if (anyNan)                   nextFlags = NZCV_UN;
    else if (bothZero)            nextFlags = NZCV_EQ;
    else if (signV[0] != signV[1]) nextFlags = signV[0] ? NZCV_LT : NZCV_GT;
    else if (magEq)               nextFlags = NZCV_EQ;
    else if (magGt ^ signV[0])    nextFlags = NZCV_GT;
    else                          nextFlags = NZCV_LT;

    nextInvalid = anySnan || (strobe.sigMode && anyNan);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nzcv      <= 4'b0000;
      invalidOp <= 1'b0;
    end else begin
      if (strobe.capture) nzcv <= nextFlags;
      invalidOp <= strobe.capture && nextInvalid;
    end
  end

  // R2: NaN operand yields unordered code
  assert_nan_unordered_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (nanV[0] || nanV[1]) |=> nzcv == NZCV_UN);
  // R3: quiet compare without signaling NaN leaves invalid low
  assert_quiet_no_invalid_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !strobe.sigMode && !snanV[0] && !snanV[1] |=> !invalidOp);
  // R4: signaling NaN always raises invalid
  assert_snan_invalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (snanV[0] || snanV[1]) |=> invalidOp);
  // R5: signaling compare raises invalid on any NaN
  assert_sig_nan_invalid_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.sigMode && (nanV[0] || nanV[1]) |=> invalidOp);
  // R7: two zeros compare equal
  assert_zero_equal_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && zeroV[0] && zeroV[1] |=> nzcv == NZCV_EQ);
  // R9: flags hold and invalid stays low between requests
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(nzcv) && !invalidOp);

endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   opcode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         resValid,
  output logic [3:0]   nzcv,
  output logic         invalidOp
);

  fcmp_strobe_t strobe;

  fcmp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opcode  (opcode),
    .strobe  (strobe),
    .resValid(resValid)
  );

  fcmp_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .nzcv     (nzcv),
    .invalidOp(invalidOp)
  );

  // R6: a presented result is always one of the four legal codes
  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (nzcv == NZCV_EQ || nzcv == NZCV_LT ||
                  nzcv == NZCV_GT || nzcv == NZCV_UN));
  // R9: invalid only alongside a valid result
  assert_invalid_qualified_R9: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> resValid);

endmodule

// File: tb/fcmp_flags_bench.sv
`timescale 1ns/1ps
module fcmp_flags_bench;

  localparam int EW   = 3;
  localparam int MW   = 2;
  localparam int W    = 1 + EW + MW;
  localparam int NVAL = 1 << W;
  localparam int EMAX = (1 << EW) - 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   opcode = 2'b00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         resValid;
  logic [3:0]   nzcv;
  logic         invalidOp;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  fcmp_flags #(.EXP_W(EW), .MAN_W(MW)) u_fcmp_flags (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .resValid(resValid), .nzcv(nzcv), .invalidOp(invalidOp)
  );

  function automatic bit isNaN(input logic [W-1:0] x);
    return (int'(x[W-2:MW]) == EMAX) && (x[MW-1:0] != 0);
  endfunction

  function automatic bit isSNaN(input logic [W-1:0] x);
    return isNaN(x) && (x[MW-1] == 1'b0);
  endfunction

  function automatic real toReal(input logic [W-1:0] x);
    int  e = int'(x[W-2:MW]);
    int  m = int'(x[MW-1:0]);
    real r;
    if (e == 0)         r = m * (2.0 ** (1 - BIAS - MW));
    else if (e == EMAX) r = 1.0e30;
    else                r = (1.0 + m / (2.0 ** MW)) * (2.0 ** (e - BIAS));
    return x[W-1] ? -r : r;
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0]   expFlags;
    logic         expInv;
    logic [W-1:0] bEff;
    logic [3:0]   lastFlags;
    string        ftag;
    string        itag;
    real          ra, rb;
    bit           nanCase;

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {resValid, nzcv}, 5'b00000);
    check("R10 reset invalid", {4'b0, invalidOp}, 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 after release", {resValid, nzcv}, 5'b00000);

    // R1..R9: full sweep with back-to-back requests
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < NVAL; a++) begin
        for (int b = 0; b < NVAL; b++) begin
          opcode  = 2'(op);
          opA     = W'(a);
          opB     = W'(b);
          inValid = 1'b1;
          bEff    = opcode[0] ? '0 : opB;
          nanCase = isNaN(opA) || isNaN(bEff);
          if (nanCase) begin
            expFlags = 4'b0011;
            ftag = "R2 unordered";
          end else begin
            ra = toReal(opA);
            rb = toReal(bEff);
            if (ra == rb)     expFlags = 4'b0110;
            else if (ra < rb) expFlags = 4'b1000;
            else              expFlags = 4'b0010;
            if (ra == 0.0 && rb == 0.0) ftag = "R7 zeros";
            else if (opcode[0])         ftag = "R1 zero variant";
            else                        ftag = "R8 R6 ordering";
          end
          expInv = isSNaN(opA) || isSNaN(bEff) || (opcode[1] && nanCase);
          if (opcode[1] && nanCase)            itag = "R5 signaling invalid";
          else if (isSNaN(opA) || isSNaN(bEff)) itag = "R4 snan invalid";
          else                                 itag = "R3 no invalid";
          @(negedge clk);
          check($sformatf("%s op=%0d a=%0h b=%0h", ftag, op, a, b),
                {resValid, nzcv}, {1'b1, expFlags});
          check($sformatf("%s op=%0d a=%0h b=%0h", itag, op, a, b),
                {4'b0, invalidOp}, {4'b0, expInv});
        end
      end
    end

    // R9: idle cycles hold flags, drop valid and invalid
    // last request was signaling zero variant with a = NaN -> unordered, invalid
    lastFlags = nzcv;
    inValid = 1'b0;
    opA = '1;
    opB = '1;
    @(negedge clk);
    check("R9 idle valid/flags", {resValid, nzcv}, {1'b0, lastFlags});
    check("R9 idle invalid", {4'b0, invalidOp}, 5'b0);
    @(negedge clk);
    check("R9 hold flags", {resValid, nzcv}, {1'b0, lastFlags});

    // R6: single request after gap, -1.0 versus +1.0 gives less
    opcode = 2'b00;
    opA = {1'b1, EW'(BIAS), MW'(0)};
    opB = {1'b0, EW'(BIAS), MW'(0)};
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 less after gap", {resValid, nzcv}, 5'b11000);
    @(negedge clk);
    check("R9 single pulse", {resValid, nzcv}, 5'b01000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule